// File: doc/BRIEF.md
# Presettable Binary/Decade Up-Down Counter Stage

This block is one 4-bit counting stage. It counts either through the full binary range 0 to 15 or through the decimal digit range 0 to 9, and it counts in either direction. Both the range and the direction can change while it runs. Counting is gated by an active-low carry input. A preset-enable input forces the parallel jam value into the stage without waiting for a clock edge. An active-low carry output flags the terminal count, so several stages on one shared clock form a multi-digit counter. Each stage's carry output drives the carry input of the next, more significant stage.

The block has no data stream, so every pin is a plain level-sensitive control or status signal. The jam value must stay stable for as long as preset-enable is high.

Top module: `updn_counter`

## Requirements
- R1: With `bin_mode`=1 (binary), counting up steps through 0..15 and wraps from 15 to 0.
- R2: With `bin_mode`=0 (decade), counting up steps through 0..9 and wraps from 9 to 0. The mode is sampled at each clock edge, so it can switch at run time.
- R3: With `count_up`=0 (down), the count decrements, and 0 wraps to 9 in decade mode or to 15 in binary mode. `count_up`=1 means up.
- R4: The count changes on a rising clock edge only when `cin_n`=0 and `preset_en`=0. Otherwise it holds.
- R5: While `preset_en`=1, `count` equals `jam` with no clock edge needed, and clock edges do not change it. After release, the stage keeps the jam value.
- R6: `cout_n` is 0 exactly when `cin_n`=0 and the stage is at its top count while counting up, or at 0 while counting down. The top count is 9 in decade mode and 15 in binary mode. Otherwise `cout_n` is 1, and it follows its inputs combinationally.
- R7: In decade mode, a preset value of 10..15 counts up by one per edge with 15 wrapping to 0, and counts down by one per edge. `cout_n` stays 1 at 15 in decade mode.
- R8: `rst`=1 clears the count to 0 asynchronously and overrides `preset_en`.
- R9: Two stages on one clock, with the low stage's `cout_n` wired to the high stage's `cin_n`, count as a two-digit decade counter 00..99 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous active-high clear |
| bin_mode | input | 1 | 1 = binary range, 0 = decade range |
| count_up | input | 1 | 1 = count up, 0 = count down |
| cin_n | input | 1 | Active-low carry in / count enable |
| preset_en | input | 1 | Active-high asynchronous load of `jam` |
| jam | input | W (4) | Parallel preset value |
| count | output | W (4) | Current count |
| cout_n | output | 1 | Active-low terminal-count carry out |

## Verification
The embedded assertions check these properties on every cycle:
- the hold rule;
- the transparent preset;
- that a decade stage already inside 0..9 never leaves that range;
- the binary 15-to-0 wrap;
- that a low carry output only ever appears with an enabled carry input at 0 or at the top count.

Only the bench's scenarios can show the following:
- the exact sequences and both wrap directions;
- the behaviour after a decade preset to 10..15;
- a mode change taking effect at the next edge;
- the full 00..99 ripple of a two-stage chain in both directions, checked against a reference model every cycle.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} dir_e;
  typedef enum logic {RANGE_DEC = 1'b0, RANGE_BIN = 1'b1} range_e;
endpackage

// File: rtl/updn_limit.sv
module updn_limit
  import updn_pkg::*;
#(
  parameter int W       = 4,
  parameter int DEC_TOP = 9
) (
  input  range_e         rng,
  output logic [W-1:0]   top
);
  localparam logic [W-1:0] BIN_V = {W{1'b1}};
  localparam logic [W-1:0] DEC_V = W'(DEC_TOP);

  always_comb begin
    if (rng == RANGE_BIN) top = BIN_V;
    else                  top = DEC_V;
  end
endmodule

// File: rtl/updn_step.sv
module updn_step
  import updn_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] top,
  input  dir_e         dir,
  output logic [W-1:0] nxt
);
  always_comb begin
    if (dir == DIR_UP) begin
      // equality to top wraps; values above top roll over naturally at 2**W
      if (cur == top) nxt = '0;
      else            nxt = cur + 1'b1;
    end else begin
      if (cur == '0)  nxt = top;
      else            nxt = cur - 1'b1;
    end
  end
endmodule

// File: rtl/updn_carry.sv
module updn_carry
  import updn_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] top,
  input  dir_e         dir,
  input  logic         cin_n,
  output logic         cout_n
);
  logic at_end;

  always_comb begin
    if (dir == DIR_UP) at_end = (cur == top);
    else               at_end = (cur == '0);
    cout_n = ~(~cin_n & at_end);
  end
endmodule

// File: rtl/updn_counter.sv
module updn_counter
  import updn_pkg::*;
#(
  parameter int W       = 4,
  parameter int DEC_TOP = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bin_mode,
  input  logic         count_up,
  input  logic         cin_n,
  input  logic         preset_en,
  input  logic [W-1:0] jam,
  output logic [W-1:0] count,
  output logic         cout_n
);
  localparam logic [W-1:0] DEC_V = W'(DEC_TOP);
  localparam logic [W-1:0] BIN_V = {W{1'b1}};

  range_e       rng;
  dir_e         dir;
  logic [W-1:0] top;
  logic [W-1:0] nxt;
  logic [W-1:0] cnt_q;

  assign rng = range_e'(bin_mode);
  assign dir = dir_e'(count_up);

  updn_limit #(.W(W), .DEC_TOP(DEC_TOP)) u_limit (
    .rng (rng),
    .top (top)
  );

  updn_step #(.W(W)) u_step (
    .cur (cnt_q),
    .top (top),
    .dir (dir),
    .nxt (nxt)
  );

  // clear beats load, load beats counting
  always_ff @(posedge clk or posedge rst or posedge preset_en) begin
    if (rst)             cnt_q <= '0;
    else if (preset_en)  cnt_q <= jam;
    else if (!cin_n)     cnt_q <= nxt;
  end

  // transparent view of jam while the load is held
  assign count = (preset_en && !rst) ? jam : cnt_q;

  updn_carry #(.W(W)) u_carry (
    .cur    (count),
    .top    (top),
    .dir    (dir),
    .cin_n  (cin_n),
    .cout_n (cout_n)
  );

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!preset_en && $past(cin_n) && !$past(preset_en)) |-> count == $past(count));

  a_r5_preset_follow: assert property (@(posedge clk) disable iff (rst)
    preset_en |-> count == jam);

  a_r2_decade_stays: assert property (@(posedge clk) disable iff (rst)
    (!preset_en && !bin_mode && count <= DEC_V) |=> (preset_en || count <= DEC_V));

  a_r1_bin_wrap: assert property (@(posedge clk) disable iff (rst)
    (!preset_en && !cin_n && count_up && bin_mode && count == BIN_V) |=> (preset_en || count == '0));

  a_r6_carry_cond: assert property (@(posedge clk) disable iff (rst)
    !cout_n |-> (!cin_n && (count == '0 || count == DEC_V || count == BIN_V)));
endmodule

// File: tb/tb_updn_counter.sv
module tb_updn_counter;
  logic       clk = 1'b0;
  logic       rst, bin_mode, count_up, cin_n, pre_lo, pre_hi;
  logic [3:0] jam_lo, jam_hi, cnt_lo, cnt_hi;
  logic       co_lo, co_hi;

  always #5 clk = ~clk;

  updn_counter dut (
    .clk(clk), .rst(rst), .bin_mode(bin_mode), .count_up(count_up),
    .cin_n(cin_n), .preset_en(pre_lo), .jam(jam_lo),
    .count(cnt_lo), .cout_n(co_lo)
  );

  updn_counter dut_hi (
    .clk(clk), .rst(rst), .bin_mode(bin_mode), .count_up(count_up),
    .cin_n(co_lo), .preset_en(pre_hi), .jam(jam_hi),
    .count(cnt_hi), .cout_n(co_hi)
  );

  typedef struct {
    int    lo;
    int    hi;
    bit    clo;
    bit    chi;
    string tag;
  } exp_t;

  exp_t sb[$];
  int   checks = 0;
  int   fails  = 0;
  int   m_lo, m_hi;
  bit   done = 0;

  function automatic int top_of(bit b);
    return b ? 15 : 9;
  endfunction

  function automatic int nxt_of(int v, bit b, bit up);
    if (up) return (v == top_of(b)) ? 0 : (v + 1) % 16;
    return (v == 0) ? top_of(b) : v - 1;
  endfunction

  function automatic bit carry_of(int v, bit b, bit up, bit cin);
    return !(!cin && ((up && v == top_of(b)) || (!up && v == 0)));
  endfunction

  task automatic chk(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  // driver: called just after a falling edge with inputs already set
  task automatic step(string tag);
    exp_t e;
    bit   c_lo;
    c_lo = carry_of(m_lo, bin_mode, count_up, cin_n);
    if (!pre_hi && !c_lo)  m_hi = nxt_of(m_hi, bin_mode, count_up);
    if (!pre_lo && !cin_n) m_lo = nxt_of(m_lo, bin_mode, count_up);
    e.lo  = m_lo;
    e.hi  = m_hi;
    e.clo = carry_of(m_lo, bin_mode, count_up, cin_n);
    e.chi = carry_of(m_hi, bin_mode, count_up, e.clo);
    e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic preset(int lo, int hi);
    pre_lo = 1'b1; pre_hi = 1'b1;
    jam_lo = 4'(lo); jam_hi = 4'(hi);
    #1;
    chk("R5 lo immediate", int'(cnt_lo), lo);
    chk("R5 hi immediate", int'(cnt_hi), hi);
    @(posedge clk); #1;
    chk("R5 lo held over edge", int'(cnt_lo), lo);
    @(negedge clk);
    pre_lo = 1'b0; pre_hi = 1'b0;
    m_lo = lo; m_hi = hi;
    #1;
    chk("R5 lo after release", int'(cnt_lo), lo);
  endtask

  // monitor: compares scoreboard items after each rising edge
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      chk({e.tag, " lo"}, int'(cnt_lo), e.lo);
      chk({e.tag, " hi"}, int'(cnt_hi), e.hi);
      chk({e.tag, "/R6 co_lo"}, int'(co_lo), int'(e.clo));
      chk({e.tag, "/R6 co_hi"}, int'(co_hi), int'(e.chi));
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; bin_mode = 1'b1; count_up = 1'b1; cin_n = 1'b1;
    pre_lo = 1'b1; pre_hi = 1'b0; jam_lo = 4'd5; jam_hi = 4'd0;
    #3;
    chk("R8 reset overrides preset", int'(cnt_lo), 0);
    chk("R8 reset carry idle", int'(co_lo), 1);
    #20 pre_lo = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    m_lo = 0; m_hi = 0;
    @(negedge clk);

    cin_n = 1'b0;
    repeat (17) step("R1 binary up");

    preset(0, 0);
    bin_mode = 1'b0;
    repeat (12) step("R2 decade up");
    count_up = 1'b0;
    repeat (12) step("R3 decade down");
    bin_mode = 1'b1;
    preset(1, 0);
    repeat (3) step("R3 binary down");

    cin_n = 1'b1;
    repeat (4) step("R4 hold");
    cin_n = 1'b0;

    bin_mode = 1'b0; count_up = 1'b1;
    preset(12, 0);
    repeat (5) step("R7 decade up from 12");
    count_up = 1'b0;
    preset(12, 0);
    repeat (4) step("R7 decade down from 12");

    count_up = 1'b1; bin_mode = 1'b1;
    preset(9, 0);
    step("R2 runtime binary");
    bin_mode = 1'b0;
    preset(9, 0);
    step("R2 runtime decade");

    preset(0, 0);
    bin_mode = 1'b0; count_up = 1'b1;
    repeat (100) step("R9 chain up");
    count_up = 1'b0;
    repeat (100) step("R9 chain down");

    @(posedge clk); #4;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule